// File: doc/BRIEF.md
# Serial-Search Spreading-Code Acquisition Engine

This block finds the code phase of a long pseudorandom spreading code in a received baseband stream using one correlator only. The received samples arrive at two per chip together with a locally generated replica chip. For each code-phase hypothesis, the block correlates one full code period of samples against the replica. It then compares the absolute value of that sum against a programmable threshold. If the threshold is not exceeded, the block moves to the next hypothesis, half a chip later.

The block does not keep a delay line for the replica. It moves the replica relative to the received stream by asking the replica generator to skip one sample, using the `rep_slip` output. With the default 4095-chip code there are 8190 hypotheses, each lasting one code period. At 64 ns chips a full sweep takes about 2.15 s, and a hit at a uniformly placed phase is found in about half that time. Tracking and data recovery belong to other blocks.

Top module: `serial_search_acq`

## Requirements
- R1: After reset, `locked`, `hyp_offset`, `corr_mag`, `sweep_done` and `rep_slip` are all zero, and the block ignores samples until `start` is seen.
- R2: A hypothesis sums exactly 2*CODE_LEN accepted samples. A sample taken with `rep_chip` = 0 is added and one taken with `rep_chip` = 1 is subtracted. When `smp_valid` is held high, the decision happens on the clock edge after the dwell's last sample.
- R3: A hypothesis is a hit only when the absolute sum is strictly greater than `threshold`; a sum equal to the threshold is a miss.
- R4: On a hit, `locked` rises at the decision edge. `hyp_offset` then gives the number of half-chip steps taken since `start`, and `corr_mag` gives the absolute sum, so a sum of either polarity locks. With `smp_valid` held high and a hit on the first hypothesis, this edge is the 15th after `start` in a 7-chip configuration.
- R5: On a miss, `hyp_offset` increments, the sum is cleared, and `rep_slip` goes high. `rep_slip` stays high until the next valid sample in the search. The block discards that sample, and the replica generator must hold its phase for it, which moves the replica half a chip later.
- R6: After 2*CODE_LEN consecutive misses, `hyp_offset` wraps to 0 and `sweep_done` rises. `sweep_done` stays high until the next `start`, and the search keeps running.
- R7: While locked, samples are ignored. `locked`, `hyp_offset` and `corr_mag` hold their values until `start`.
- R8: `start` in any state, including the decision cycle of a hit, returns the block to searching with offset 0. It clears `locked`, `sweep_done`, `rep_slip` and the sum, and it takes priority over the decision.
- R9: Cycles with `smp_valid` low contribute nothing and do not end a dwell, so gaps in the stream do not change which offset is found.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Restart search at offset 0 |
| smp_valid | input | 1 | Sample and replica chip are valid this cycle |
| smp | input | SAMPLE_W | Signed received sample, two per chip |
| rep_chip | input | 1 | Local replica chip (0 = +1, 1 = -1) |
| threshold | input | ACC_W | Detection threshold on the absolute sum |
| locked | output | 1 | A hypothesis exceeded the threshold |
| hyp_offset | output | OFF_W | Current or winning offset in half chips |
| corr_mag | output | ACC_W | Absolute sum of the last decided hypothesis |
| sweep_done | output | 1 | Sticky: all hypotheses tested once |
| rep_slip | output | 1 | Replica generator must hold for the next valid sample |

## Verification
The case that matters most is a restart landing in the same cycle as a hit decision. To provoke it, the bench aligns the stream so that the first hypothesis is a hit, then asserts `start` again on exactly the edge where that decision falls. It passes only if `locked` stays low, the offset reads 0, and a lock follows a full dwell later. A second coincidence is the last miss of a sweep, where the offset wrap, the rise of `sweep_done` and the raising of `rep_slip` share one edge; the bench checks the edge counted from `start` at which each becomes visible.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DWELL  = 2'd1,
    ST_DECIDE = 2'd2,
    ST_LOCK   = 2'd3
  } acq_state_t;
endpackage

// File: rtl/acq_integrator.sv
module acq_integrator #(
  parameter int SAMPLE_W = 8,
  parameter int ACC_W    = 22
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       take,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic                       chip,
  output logic        [ACC_W-1:0]    acc_mag
);
  logic signed [ACC_W-1:0] acc_q, acc_d, ext, term;

  always_comb begin
    ext  = ACC_W'(smp);
    term = chip ? -ext : ext;
    acc_d = acc_q;
    if (clr)       acc_d = '0;
    else if (take) acc_d = acc_q + term;
    acc_mag = acc_q[ACC_W-1] ? ACC_W'(-acc_q) : ACC_W'(acc_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end
endmodule

// File: rtl/acq_hyp_counter.sv
module acq_hyp_counter #(
  parameter int HYP_N = 8190,
  parameter int OFF_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             adv,
  output logic [OFF_W-1:0] off_q,
  output logic             sweep_q
);
  logic [OFF_W-1:0] off_d;
  logic             sweep_d, wrap;

  always_comb begin
    wrap    = (off_q == OFF_W'(HYP_N - 1));
    off_d   = off_q;
    sweep_d = sweep_q;
    if (start) begin
      off_d   = '0;
      sweep_d = 1'b0;
    end else if (adv) begin
      off_d = wrap ? '0 : off_q + 1'b1;
      if (wrap) sweep_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      off_q   <= '0;
      sweep_q <= 1'b0;
    end else begin
      off_q   <= off_d;
      sweep_q <= sweep_d;
    end
  end
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
#(
  parameter int HYP_N = 8190,
  parameter int CNT_W = 13
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       smp_valid,
  input  logic       hit,
  output acq_state_t state_q,
  output logic       take,
  output logic       clr,
  output logic       adv,
  output logic       slip_q
);
  acq_state_t       state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             slip_d, last, miss;

  always_comb begin
    take = (state_q == ST_DWELL) && smp_valid && !slip_q && !start;
    last = take && (cnt_q == CNT_W'(HYP_N - 1));
    miss = (state_q == ST_DECIDE) && !hit;
    adv  = miss && !start;
    clr  = start || miss;

    state_d = state_q;
    if (start) state_d = ST_DWELL;
    else begin
      case (state_q)
        ST_DWELL:  if (last) state_d = ST_DECIDE;
        ST_DECIDE: state_d = hit ? ST_LOCK : ST_DWELL;
        default:   state_d = state_q;
      endcase
    end

    cnt_d = cnt_q;
    if (start || adv || last) cnt_d = '0;
    else if (take)            cnt_d = cnt_q + 1'b1;

    slip_d = slip_q;
    if (start)                                    slip_d = 1'b0;
    else if (adv)                                 slip_d = 1'b1;
    else if ((state_q == ST_DWELL) && smp_valid)  slip_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      slip_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      slip_q  <= slip_d;
    end
  end
endmodule

// File: rtl/serial_search_acq.sv
module serial_search_acq
  import acq_pkg::*;
#(
  parameter int CODE_LEN = 4095,
  parameter int SAMPLE_W = 8,
  parameter int OFF_W    = $clog2(2 * CODE_LEN),
  parameter int ACC_W    = SAMPLE_W + $clog2(2 * CODE_LEN) + 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       smp_valid,
  input  logic signed [SAMPLE_W-1:0] smp,
  input  logic                       rep_chip,
  input  logic        [ACC_W-1:0]    threshold,
  output logic                       locked,
  output logic        [OFF_W-1:0]    hyp_offset,
  output logic        [ACC_W-1:0]    corr_mag,
  output logic                       sweep_done,
  output logic                       rep_slip
);
  localparam int HYP_N = 2 * CODE_LEN;
  localparam int CNT_W = $clog2(HYP_N);

  acq_state_t       state;
  logic             take, clr, adv, hit, mag_load;
  logic [ACC_W-1:0] acc_mag, mag_q, mag_d;

  acq_fsm #(.HYP_N(HYP_N), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid),
    .hit(hit), .state_q(state), .take(take), .clr(clr), .adv(adv),
    .slip_q(rep_slip)
  );

  acq_integrator #(.SAMPLE_W(SAMPLE_W), .ACC_W(ACC_W)) u_int (
    .clk(clk), .rst_n(rst_n), .clr(clr), .take(take), .smp(smp),
    .chip(rep_chip), .acc_mag(acc_mag)
  );

  acq_hyp_counter #(.HYP_N(HYP_N), .OFF_W(OFF_W)) u_hyp (
    .clk(clk), .rst_n(rst_n), .start(start), .adv(adv),
    .off_q(hyp_offset), .sweep_q(sweep_done)
  );

  always_comb begin
    hit      = acc_mag > threshold;
    mag_load = (state == ST_DECIDE) && !start;
    mag_d    = mag_load ? acc_mag : mag_q;
    locked   = (state == ST_LOCK);
    corr_mag = mag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mag_q <= '0;
    else        mag_q <= mag_d;
  end
endmodule

// File: rtl/acq_checker.sv
module acq_checker #(
  parameter int CODE_LEN = 4095,
  parameter int OFF_W    = 13,
  parameter int ACC_W    = 22
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [ACC_W-1:0] threshold,
  input logic             locked,
  input logic [OFF_W-1:0] hyp_offset,
  input logic [ACC_W-1:0] corr_mag,
  input logic             sweep_done,
  input logic             rep_slip
);
  assert_start_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (hyp_offset == '0 && !locked && !sweep_done && !rep_slip));

  assert_lock_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !start) |=> (locked && $stable(hyp_offset) && $stable(corr_mag)));

  assert_lock_above_thr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> (corr_mag > $past(threshold)));

  assert_sweep_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sweep_done && !start) |=> sweep_done);

  assert_sweep_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sweep_done) |-> (hyp_offset == '0));

  assert_offset_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (hyp_offset == $past(hyp_offset) ||
                hyp_offset == $past(hyp_offset) + OFF_W'(1) ||
                hyp_offset == '0));

  assert_slip_only_search_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rep_slip |-> !locked);
endmodule

bind serial_search_acq acq_checker #(
  .CODE_LEN(CODE_LEN), .OFF_W(OFF_W), .ACC_W(ACC_W)
) u_acq_checker (
  .clk(clk), .rst_n(rst_n), .start(start), .threshold(threshold),
  .locked(locked), .hyp_offset(hyp_offset), .corr_mag(corr_mag),
  .sweep_done(sweep_done), .rep_slip(rep_slip)
);

// File: tb/test_serial_search_acq.sv
module test_serial_search_acq;
  localparam int CODE_LEN = 7;
  localparam int SAMPLE_W = 6;
  localparam int HYP      = 2 * CODE_LEN;
  localparam int OFF_W    = $clog2(HYP);
  localparam int ACC_W    = SAMPLE_W + $clog2(HYP) + 1;
  localparam logic [CODE_LEN-1:0] CODE = 7'b1110010;
  localparam int A = 3;

  logic clk = 1'b0;
  logic rst_n, start, smp_valid, rep_chip;
  logic signed [SAMPLE_W-1:0] smp;
  logic [ACC_W-1:0] threshold;
  logic locked, sweep_done, rep_slip;
  logic [OFF_W-1:0] hyp_offset;
  logic [ACC_W-1:0] corr_mag;

  int n_tests = 0, n_fail = 0;
  int rx_idx = 0, rep_idx = 0;
  int dly = 0, pol = 1, gap_mode = 0, gap_ph = 0;
  bit slip_seen = 0, drv_valid = 0;

  always #5 clk = ~clk;

  serial_search_acq #(.CODE_LEN(CODE_LEN), .SAMPLE_W(SAMPLE_W)) i_serial_search_acq (
    .clk(clk), .rst_n(rst_n), .start(start), .smp_valid(smp_valid), .smp(smp),
    .rep_chip(rep_chip), .threshold(threshold), .locked(locked),
    .hyp_offset(hyp_offset), .corr_mag(corr_mag), .sweep_done(sweep_done),
    .rep_slip(rep_slip)
  );

  function automatic int bsign(input int n);
    return CODE[(n % HYP) / 2] ? -1 : 1;
  endfunction

  function automatic int corr(input int s);
    int acc = 0;
    for (int n = 0; n < HYP; n++) acc += bsign(n + s) * bsign(n);
    return acc;
  endfunction

  function automatic int absi(input int v);
    return v < 0 ? -v : v;
  endfunction

  function automatic int exp_k(input int shift, input int thr);
    for (int k = 0; k < HYP; k++)
      if (absi(A * corr((shift + k) % HYP)) > thr) return k;
    return -1;
  endfunction

  // replica generator and received stream model
  always @(posedge clk) begin
    if (drv_valid) begin
      rx_idx <= rx_idx + 1;
      if (!slip_seen) rep_idx <= rep_idx + 1;
    end
  end

  always @(negedge clk) begin
    slip_seen = rep_slip;
    gap_ph    = gap_ph + 1;
    drv_valid = (gap_mode != 0) ? (gap_ph % 3 != 0) : 1'b1;
    smp_valid = drv_valid;
    smp       = SAMPLE_W'(pol * A * bsign(rx_idx + dly));
    rep_chip  = CODE[(rep_idx % HYP) / 2];
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_shift(input int target);
    int diff;
    diff = (rx_idx - rep_idx) % HYP;
    dly  = (target - diff + 2 * HYP) % HYP;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_lock(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      if (locked) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int k, t;
    rst_n = 1'b0; start = 1'b0; threshold = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    wait_edges(2);
    // R1: reset state
    chk(locked == 0, "R1 locked", locked, 0);
    chk(hyp_offset == 0, "R1 offset", hyp_offset, 0);
    chk(corr_mag == 0, "R1 mag", corr_mag, 0);
    chk(sweep_done == 0, "R1 sweep", sweep_done, 0);
    chk(rep_slip == 0, "R1 slip", rep_slip, 0);

    // R2/R4: aligned stream, hit on first hypothesis at edge 15
    threshold = ACC_W'(41); pol = 1; set_shift(0);
    pulse_start();
    wait_edges(14);
    chk(locked == 0, "R2 no decision before dwell end", locked, 0);
    wait_edges(1);
    chk(locked == 1, "R4 lock at edge 15", locked, 1);
    chk(hyp_offset == 0, "R4 offset", hyp_offset, 0);
    chk(corr_mag == ACC_W'(A * HYP), "R2 magnitude", corr_mag, A * HYP);

    // R7: lock holds while samples keep coming
    wait_edges(40);
    chk(locked == 1 && hyp_offset == 0, "R7 lock held", hyp_offset, 0);
    chk(corr_mag == ACC_W'(A * HYP), "R7 mag held", corr_mag, A * HYP);

    // R8: restart collides with the hit decision
    set_shift(0);
    pulse_start();
    wait_edges(14);
    pulse_start();
    chk(locked == 0, "R8 start beats hit", locked, 0);
    chk(hyp_offset == 0, "R8 offset zero", hyp_offset, 0);
    wait_edges(14);
    chk(locked == 0, "R8 relock not early", locked, 0);
    wait_edges(1);
    chk(locked == 1, "R8 relock after full dwell", locked, 1);

    // R3/R5/R6: threshold equal to peak never locks; sweep wraps
    threshold = ACC_W'(A * HYP); set_shift(0);
    pulse_start();
    wait_edges(15);
    chk(locked == 0, "R3 equal is a miss", locked, 0);
    chk(hyp_offset == 1, "R5 offset step", hyp_offset, 1);
    chk(rep_slip == 1, "R5 slip raised", rep_slip, 1);
    chk(corr_mag == ACC_W'(A * HYP), "R2 miss magnitude", corr_mag, A * HYP);
    wait_edges(1);
    chk(rep_slip == 0, "R5 slip consumed", rep_slip, 0);
    wait_edges(206);
    chk(sweep_done == 0, "R6 sweep not early", sweep_done, 0);
    chk(hyp_offset == HYP - 1, "R6 last offset", hyp_offset, HYP - 1);
    wait_edges(1);
    chk(sweep_done == 1, "R6 sweep done", sweep_done, 1);
    chk(hyp_offset == 0, "R6 wrap", hyp_offset, 0);
    wait_edges(30);
    chk(sweep_done == 1 && locked == 0, "R6 sticky", sweep_done, 1);

    // R4: inverted polarity still locks, after several slips
    pol = -1; threshold = ACC_W'(41); set_shift(6);
    k = exp_k(6, 41);
    pulse_start();
    chk(sweep_done == 0, "R8 sweep cleared", sweep_done, 0);
    wait_lock(600);
    chk(hyp_offset == OFF_W'(k), "R4 inverted offset", hyp_offset, k);
    chk(corr_mag == ACC_W'(A * HYP), "R4 absolute mag", corr_mag, A * HYP);

    // R3: low threshold accepts a half-chip neighbour
    pol = 1; t = 5 * A; threshold = ACC_W'(t); set_shift(5);
    k = exp_k(5, t);
    pulse_start();
    wait_lock(600);
    chk(locked == 1 && hyp_offset == OFF_W'(k), "R3 low threshold offset", hyp_offset, k);
    chk(corr_mag == ACC_W'(absi(A * corr((5 + k) % HYP))), "R3 low threshold mag",
        corr_mag, absi(A * corr((5 + k) % HYP)));

    // R9: gaps in the sample stream
    gap_mode = 1; threshold = ACC_W'(41); set_shift(4);
    k = exp_k(4, 41);
    pulse_start();
    wait_lock(1500);
    chk(locked == 1 && hyp_offset == OFF_W'(k), "R9 gapped offset", hyp_offset, k);
    chk(corr_mag == ACC_W'(A * HYP), "R9 gapped mag", corr_mag, A * HYP);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule